// File: doc/BRIEF.md
# Performance Monitor Event Counter Unit

This unit counts processor performance events so software can measure code sections and find hot spots. It has one free-running cycle counter and a parameterised set of event counters, `NUM_CNT` of them. Each event counter takes one event from a fixed menu of single-bit pipeline event inputs. Some events count in every cycle their condition holds. One counts once per contiguous run. Write-backs are weighted by the number of half lines moved. The software PC-change event is qualified so that PC changes that come with a mode change are not counted.

Every counter can be preloaded through the register port. Software writes 2^32 minus the sampling interval, and the wrap to zero then sets a sticky flag. The flag can raise an interrupt and captures the current PC as a sample. This supports both time-based sampling (cycle counter) and event-based sampling (event counters). Register access uses a single-cycle write port and a combinational read port.

Top module: `perf_event_monitor`

## Requirements
- R1: While the control enable bit (control bit 0) is 1, the cycle counter at word address 3 increases by exactly one per clock; while it is 0 the cycle counter holds.
- R2: An event counter i (word address 4+i) selects its event through the 4-bit field at control bits [8+4i +: 4]. The codes are: 1 icache miss, 2 fetch stall, 3 dependency stall, 4 ITLB miss, 5 DTLB miss, 6 branch, 7 mispredict, 8 retire, 9 data-buffer-full (level). These level events add one in every enabled cycle the input is high.
- R3: Code 10 adds one only in a cycle where the data-buffer-full input is high and was low in the previous cycle, so each contiguous run counts once.
- R4: Code 13 adds the 2-bit half-line write-back count each enabled cycle, so a full line (value 2) adds two.
- R5: Code 14 counts a PC write only when the mode-change input is low in the same cycle.
- R6: Code 11 (data-cache access) and code 12 (data-cache miss) do not count in cycles where the maintenance qualifier is high.
- R7: A register write to a counter address loads the written value at the next edge, and it takes priority over any count in that cycle.
- R8: Writing control with bit 1 set clears every counter at the next edge and leaves the overflow flags unchanged. Control bit 1 always reads back 0.
- R9: A counter wrap from all ones past zero sets a sticky flag in the status word at address 1 (bit 0 cycle counter, bit 1+i event counter i). Writing 1 to a status bit clears it, and a new wrap in the same cycle wins over the clear.
- R10: `irq` is high exactly when some status flag k is set and its interrupt enable, control bit 2+k, is 1.
- R11: On the edge where any counter wraps while all status flags are clear, `pc_in` is captured into the sample register at address 2. The sample holds while any flag is set.
- R12: Select codes 0 and 15 never count, and no event counter changes while the enable bit is 0 except by load or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Write word address |
| reg_wr_data | input | DATA_W | Write data |
| reg_rd_addr | input | ADDR_W | Read word address |
| reg_rd_data | output | DATA_W | Read data (combinational) |
| ev_icache_miss | input | 1 | Instruction cache miss needing external fetch |
| ev_fetch_stall | input | 1 | Fetch cannot deliver an instruction |
| ev_dep_stall | input | 1 | Data dependency stall |
| ev_itlb_miss | input | 1 | Instruction TLB miss |
| ev_dtlb_miss | input | 1 | Data TLB miss |
| ev_branch | input | 1 | Branch executed |
| ev_mispredict | input | 1 | Branch mispredicted |
| ev_retire | input | 1 | Instruction executed |
| ev_dbuf_full | input | 1 | Data cache buffers full stall |
| ev_dc_access | input | 1 | Data cache access |
| ev_dc_miss | input | 1 | Data cache miss |
| ev_dc_maint | input | 1 | Current data cache operation is maintenance |
| ev_wb_halves | input | 2 | Half lines written back this cycle |
| ev_pc_write | input | 1 | Instruction wrote the PC |
| ev_mode_change | input | 1 | PC write comes with a mode change |
| pc_in | input | PC_W | Current program counter |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench builds the unit with three event counters and keeps the 32-bit counter width and PC width. The third counter places a select field at bits [16 +: 4] and a status flag at bit 3. This exercises field decoding beyond the first two slots. Because counters are 32 bits, wraps are reached by preloading values a few counts below all ones. Running several counters side by side lets simultaneous wraps, wraps during a flag clear, and PC capture races against already-set flags occur within a few thousand cycles.

// File: rtl/pem_pkg.sv
package pem_pkg;

  localparam int SEL_W = 4;
  localparam int INC_W = 2;

  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_PCS  = 2;
  localparam int A_CLK  = 3;
  localparam int A_EVT0 = 4;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_CLR_BIT = 1;
  localparam int CTRL_IE_LSB  = 2;
  localparam int CTRL_SEL_LSB = 8;

  typedef enum logic [SEL_W-1:0] {
    EV_OFF         = 4'd0,
    EV_IC_MISS     = 4'd1,
    EV_FETCH_STALL = 4'd2,
    EV_DEP_STALL   = 4'd3,
    EV_ITLB        = 4'd4,
    EV_DTLB        = 4'd5,
    EV_BRANCH      = 4'd6,
    EV_MISPRED     = 4'd7,
    EV_RETIRE      = 4'd8,
    EV_DBUF_LVL    = 4'd9,
    EV_DBUF_RUN    = 4'd10,
    EV_DC_ACC      = 4'd11,
    EV_DC_MISS     = 4'd12,
    EV_DC_WB       = 4'd13,
    EV_SW_PC       = 4'd14,
    EV_SPARE       = 4'd15
  } ev_code_e;

  typedef struct packed {
    logic       ic_miss;
    logic       fetch_stall;
    logic       dep_stall;
    logic       itlb_miss;
    logic       dtlb_miss;
    logic       branch;
    logic       mispred;
    logic       retire;
    logic       dbuf_full;
    logic       dc_access;
    logic       dc_miss;
    logic       dc_maint;
    logic       pc_write;
    logic       mode_change;
    logic [1:0] wb_halves;
  } ev_bus_t;

  // one-bit event to increment width
  function automatic logic [INC_W-1:0] one_step(input logic b);
    return {{(INC_W-1){1'b0}}, b};
  endfunction

  // increment contributed this cycle by the selected event
  function automatic logic [INC_W-1:0] event_weight(input ev_code_e code,
                                                    input ev_bus_t ev,
                                                    input logic run_start);
    logic [INC_W-1:0] w;
    case (code)
      EV_IC_MISS:     w = one_step(ev.ic_miss);
      EV_FETCH_STALL: w = one_step(ev.fetch_stall);
      EV_DEP_STALL:   w = one_step(ev.dep_stall);
      EV_ITLB:        w = one_step(ev.itlb_miss);
      EV_DTLB:        w = one_step(ev.dtlb_miss);
      EV_BRANCH:      w = one_step(ev.branch);
      EV_MISPRED:     w = one_step(ev.mispred);
      EV_RETIRE:      w = one_step(ev.retire);
      EV_DBUF_LVL:    w = one_step(ev.dbuf_full);
      EV_DBUF_RUN:    w = one_step(run_start);
      EV_DC_ACC:      w = one_step(ev.dc_access & ~ev.dc_maint);
      EV_DC_MISS:     w = one_step(ev.dc_miss & ~ev.dc_maint);
      EV_DC_WB:       w = ev.wb_halves;
      EV_SW_PC:       w = one_step(ev.pc_write & ~ev.mode_change);
      default:        w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/pem_run_edge.sv
module pem_run_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/pem_event_sel.sv
module pem_event_sel
  import pem_pkg::*;
(
  input  logic              en,
  input  logic [SEL_W-1:0]  sel,
  input  ev_bus_t           ev,
  input  logic              run_start,
  output logic [INC_W-1:0]  inc
);
  logic [INC_W-1:0] raw_w;

  always_comb begin
    raw_w = event_weight(ev_code_e'(sel), ev, run_start);
    inc   = en ? raw_w : '0;
  end
endmodule

// File: rtl/pem_counter.sv
module pem_counter #(
  parameter int W     = 32,
  parameter int INC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clear,
  input  logic [W-1:0]     load_val,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     cnt,
  output logic             wrap
);
  logic [W:0] sum_ext;

  always_comb sum_ext = {1'b0, cnt} + {{(W+1-INC_W){1'b0}}, inc};

  assign wrap = sum_ext[W] & ~load & ~clear;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (clear) cnt <= '0;
    else            cnt <= sum_ext[W-1:0];
  end
endmodule

// File: rtl/perf_event_monitor.sv
module perf_event_monitor
  import pem_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int DATA_W  = 32,
  parameter int PC_W    = 32,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic              ev_icache_miss,
  input  logic              ev_fetch_stall,
  input  logic              ev_dep_stall,
  input  logic              ev_itlb_miss,
  input  logic              ev_dtlb_miss,
  input  logic              ev_branch,
  input  logic              ev_mispredict,
  input  logic              ev_retire,
  input  logic              ev_dbuf_full,
  input  logic              ev_dc_access,
  input  logic              ev_dc_miss,
  input  logic              ev_dc_maint,
  input  logic [1:0]        ev_wb_halves,
  input  logic              ev_pc_write,
  input  logic              ev_mode_change,
  input  logic [PC_W-1:0]   pc_in,
  output logic              irq
);
  localparam int NFLAG = NUM_CNT + 1;

  // ---------------- register decode ----------------
  logic [DATA_W-1:0] ctrl_q;
  logic              ctrl_en;
  logic              wr_ctrl, wr_stat, rst_all, clk_load, any_load;
  logic [NUM_CNT-1:0] evt_load;

  assign ctrl_en  = ctrl_q[CTRL_EN_BIT];
  assign wr_ctrl  = reg_wr_en && (reg_wr_addr == ADDR_W'(A_CTRL));
  assign wr_stat  = reg_wr_en && (reg_wr_addr == ADDR_W'(A_STAT));
  assign clk_load = reg_wr_en && (reg_wr_addr == ADDR_W'(A_CLK));
  assign rst_all  = wr_ctrl && reg_wr_data[CTRL_CLR_BIT];
  assign any_load = clk_load | (|evt_load);

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= reg_wr_data & ~(DATA_W'(1) << CTRL_CLR_BIT);
  end

  // ---------------- event bus ----------------
  ev_bus_t ev;
  always_comb begin
    ev.ic_miss     = ev_icache_miss;
    ev.fetch_stall = ev_fetch_stall;
    ev.dep_stall   = ev_dep_stall;
    ev.itlb_miss   = ev_itlb_miss;
    ev.dtlb_miss   = ev_dtlb_miss;
    ev.branch      = ev_branch;
    ev.mispred     = ev_mispredict;
    ev.retire      = ev_retire;
    ev.dbuf_full   = ev_dbuf_full;
    ev.dc_access   = ev_dc_access;
    ev.dc_miss     = ev_dc_miss;
    ev.dc_maint    = ev_dc_maint;
    ev.pc_write    = ev_pc_write;
    ev.mode_change = ev_mode_change;
    ev.wb_halves   = ev_wb_halves;
  end

  logic dbuf_run_start;
  pem_run_edge u_run (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (ev_dbuf_full),
    .rise (dbuf_run_start)
  );

  // ---------------- counters ----------------
  logic [NFLAG-1:0]                 wrap_vec;
  logic [DATA_W-1:0]                clk_cnt;
  logic [NUM_CNT-1:0][DATA_W-1:0]   ev_cnt;

  pem_counter #(.W(DATA_W), .INC_W(INC_W)) u_clk_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (clk_load),
    .clear   (rst_all),
    .load_val(reg_wr_data),
    .inc     ({{(INC_W-1){1'b0}}, ctrl_en}),
    .cnt     (clk_cnt),
    .wrap    (wrap_vec[0])
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_evt
    logic [INC_W-1:0] inc_i;

    assign evt_load[i] = reg_wr_en && (reg_wr_addr == ADDR_W'(A_EVT0 + i));

    pem_event_sel u_sel (
      .en       (ctrl_en),
      .sel      (ctrl_q[CTRL_SEL_LSB + SEL_W*i +: SEL_W]),
      .ev       (ev),
      .run_start(dbuf_run_start),
      .inc      (inc_i)
    );

    pem_counter #(.W(DATA_W), .INC_W(INC_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (evt_load[i]),
      .clear   (rst_all),
      .load_val(reg_wr_data),
      .inc     (inc_i),
      .cnt     (ev_cnt[i]),
      .wrap    (wrap_vec[i+1])
    );
  end

  // ---------------- overflow flags, sample, interrupt ----------------
  logic [NFLAG-1:0] ovf_flags;
  logic [NFLAG-1:0] flag_clr;
  logic [PC_W-1:0]  pc_sample;
  logic             take_sample;

  assign flag_clr    = wr_stat ? reg_wr_data[NFLAG-1:0] : '0;
  assign take_sample = (|wrap_vec) && (ovf_flags == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flags <= '0;
      pc_sample <= '0;
    end else begin
      ovf_flags <= (ovf_flags & ~flag_clr) | wrap_vec;
      if (take_sample) pc_sample <= pc_in;
    end
  end

  assign irq = |(ovf_flags & ctrl_q[CTRL_IE_LSB +: NFLAG]);

  // ---------------- read mux ----------------
  always_comb begin
    reg_rd_data = '0;
    if (reg_rd_addr == ADDR_W'(A_CTRL)) reg_rd_data = ctrl_q;
    if (reg_rd_addr == ADDR_W'(A_STAT)) reg_rd_data = DATA_W'(ovf_flags);
    if (reg_rd_addr == ADDR_W'(A_PCS))  reg_rd_data = DATA_W'(pc_sample);
    if (reg_rd_addr == ADDR_W'(A_CLK))  reg_rd_data = clk_cnt;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (reg_rd_addr == ADDR_W'(A_EVT0 + i)) reg_rd_data = ev_cnt[i];
    end
  end

endmodule

// File: rtl/pem_checker.sv
module pem_checker #(
  parameter int N  = 2,
  parameter int W  = 32,
  parameter int PW = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ctrl_en,
  input logic                rst_all,
  input logic                clk_load,
  input logic                any_load,
  input logic                wr_stat,
  input logic [W-1:0]        clk_cnt,
  input logic [N-1:0][W-1:0] ev_cnt,
  input logic [N:0]          ovf_flags,
  input logic [N:0]          wrap_vec,
  input logic [PW-1:0]       pc_sample,
  input logic                irq
);
  // R1
  clk_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_en && !clk_load && !rst_all) |-> clk_cnt == $past(clk_cnt) + W'(1));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ctrl_en && !any_load && !rst_all) |-> ($stable(ev_cnt) && $stable(clk_cnt)));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_stat) |-> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));

  // R9
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_vec) |=> ((ovf_flags & $past(wrap_vec)) == $past(wrap_vec)));

  // R11
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|$past(ovf_flags)) |-> $stable(pc_sample));

  // R10
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|ovf_flags));
endmodule

bind perf_event_monitor pem_checker #(.N(NUM_CNT), .W(DATA_W), .PW(PC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctrl_en  (ctrl_en),
  .rst_all  (rst_all),
  .clk_load (clk_load),
  .any_load (any_load),
  .wr_stat  (wr_stat),
  .clk_cnt  (clk_cnt),
  .ev_cnt   (ev_cnt),
  .ovf_flags(ovf_flags),
  .wrap_vec (wrap_vec),
  .pc_sample(pc_sample),
  .irq      (irq)
);

// File: tb/tb_perf_event_monitor.sv
`timescale 1ns/1ps
module tb_perf_event_monitor;
  localparam int NC = 3;
  localparam int NR = 4 + NC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [3:0] waddr = '0;
  logic [31:0] wdata = '0;
  logic [3:0] raddr = '0;
  logic [31:0] rdata;
  logic e_ic = 0, e_fs = 0, e_dep = 0, e_itlb = 0, e_dtlb = 0, e_br = 0, e_mp = 0;
  logic e_ret = 0, e_dbuf = 0, e_acc = 0, e_miss = 0, e_maint = 0, e_pcw = 0, e_mode = 0;
  logic [1:0] e_wb = 0;
  logic [31:0] pc = '0;
  logic irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  perf_event_monitor #(.NUM_CNT(NC)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(we), .reg_wr_addr(waddr), .reg_wr_data(wdata),
    .reg_rd_addr(raddr), .reg_rd_data(rdata),
    .ev_icache_miss(e_ic), .ev_fetch_stall(e_fs), .ev_dep_stall(e_dep), .ev_itlb_miss(e_itlb),
    .ev_dtlb_miss(e_dtlb), .ev_branch(e_br), .ev_mispredict(e_mp), .ev_retire(e_ret),
    .ev_dbuf_full(e_dbuf), .ev_dc_access(e_acc), .ev_dc_miss(e_miss), .ev_dc_maint(e_maint),
    .ev_wb_halves(e_wb), .ev_pc_write(e_pcw), .ev_mode_change(e_mode), .pc_in(pc), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  longint unsigned m_cnt [NC+1];   // 0 = cycle counter, k = event counter k-1
  logic [31:0] m_ctrl, m_pc;
  logic [NC:0] m_flags;
  bit m_prev;

  always @(posedge clk) begin
    int w [16];
    logic [NC:0] wr_k;
    bit en;
    longint unsigned s;
    int amt;
    if (!rst_n) begin
      foreach (m_cnt[k]) m_cnt[k] = 0;
      m_ctrl = 0; m_pc = 0; m_flags = 0; m_prev = 0;
    end else begin
      foreach (w[j]) w[j] = 0;
      w[1] = e_ic; w[2] = e_fs; w[3] = e_dep; w[4] = e_itlb; w[5] = e_dtlb;
      w[6] = e_br; w[7] = e_mp; w[8] = e_ret; w[9] = e_dbuf;
      w[10] = (e_dbuf && !m_prev) ? 1 : 0;
      w[11] = (e_acc && !e_maint) ? 1 : 0;
      w[12] = (e_miss && !e_maint) ? 1 : 0;
      w[13] = e_wb;
      w[14] = (e_pcw && !e_mode) ? 1 : 0;
      en = m_ctrl[0];
      wr_k = 0;
      for (int k = 0; k <= NC; k++) begin
        if (!en) amt = 0;
        else if (k == 0) amt = 1;
        else amt = w[m_ctrl[8 + 4*(k-1) +: 4]];
        if (we && waddr == 4'(3 + k)) m_cnt[k] = wdata;
        else if (we && waddr == 0 && wdata[1]) m_cnt[k] = 0;
        else begin
          s = m_cnt[k] + longint'(amt);
          if (s >= 64'h1_0000_0000) begin
            wr_k[k] = 1'b1;
            s = s - 64'h1_0000_0000;
          end
          m_cnt[k] = s;
        end
      end
      if (wr_k != 0 && m_flags == 0) m_pc = pc;
      if (we && waddr == 1) m_flags = m_flags & ~wdata[NC:0];
      m_flags = m_flags | wr_k;
      if (we && waddr == 0) m_ctrl = wdata & ~32'd2;
      m_prev = e_dbuf;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    logic [31:0] exp_v;
    string tag;
    if (!done) begin
      chk("R10 irq", {31'd0, irq}, {31'd0, |(m_flags & m_ctrl[2 +: NC+1])});
      for (int a = 0; a < NR; a++) begin
        raddr = 4'(a);
        #0.1;
        case (a)
          0: begin exp_v = m_ctrl; tag = "R8 ctrl"; end
          1: begin exp_v = 32'(m_flags); tag = "R9 status"; end
          2: begin exp_v = m_pc; tag = "R11 pc sample"; end
          3: begin exp_v = 32'(m_cnt[0]); tag = "R1 cycle counter"; end
          default: begin exp_v = 32'(m_cnt[a-3]); tag = "R2 event counter"; end
        endcase
        chk(tag, rdata, exp_v);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] mk(bit en, bit clr, logic [3:0] ie,
                                     logic [3:0] s0, logic [3:0] s1, logic [3:0] s2);
    return {12'd0, s2, s1, s0, 2'b00, ie, clr, en};
  endfunction

  task automatic ev_zero();
    {e_ic, e_fs, e_dep, e_itlb, e_dtlb, e_br, e_mp, e_ret} = '0;
    {e_dbuf, e_acc, e_miss, e_maint, e_pcw, e_mode} = '0;
    e_wb = 0;
  endtask

  task automatic ev_all();
    {e_ic, e_fs, e_dep, e_itlb, e_dtlb, e_br, e_mp, e_ret} = '1;
    {e_dbuf, e_acc, e_miss, e_pcw} = '1;
    e_maint = 0; e_mode = 0; e_wb = 2'd2;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1; waddr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    #1.5;
    raddr = a;
    #0.1;
    v = rdata;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // ---------------- directed and random sequences ----------------
  initial begin
    logic [31:0] v, v2;
    ev_zero();
    repeat (3) @(negedge clk);
    rd(4'd3, v); chk("R1 reset cycle counter", v, 0);
    rd(4'd1, v); chk("R9 reset status", v, 0);
    rst_n = 1;

    // R1: 7 counted edges between enable and disable writes
    wr(0, mk(1, 0, 0, 0, 0, 0));
    repeat (5) cyc();
    wr(0, mk(0, 0, 0, 0, 0, 0));
    rd(4'd3, v); chk("R1 enabled cycle count", v, 7);

    // R2, R3, R4
    wr(0, mk(0, 1, 0, 10, 3, 13));
    wr(0, mk(1, 0, 0, 10, 3, 13));
    for (int c = 0; c < 8; c++) begin
      e_dbuf = (c < 3) || (c == 4) || (c == 5);
      e_dep  = (c < 4);
      e_wb   = (c == 0) ? 2'd2 : (c == 2) ? 2'd1 : 2'd0;
      cyc();
    end
    ev_zero();
    wr(0, mk(0, 0, 0, 10, 3, 13));
    rd(4'd4, v); chk("R3 run count", v, 2);
    rd(4'd5, v); chk("R2 level dependency stall", v, 4);
    rd(4'd6, v); chk("R4 half-line write-backs", v, 3);

    // R5, R6
    wr(0, mk(0, 1, 0, 14, 11, 12));
    wr(0, mk(1, 0, 0, 14, 11, 12));
    e_pcw = 1; e_mode = 0; e_acc = 1; e_maint = 0; cyc();
    e_pcw = 1; e_mode = 1; e_acc = 1; e_maint = 1; e_miss = 1; cyc();
    e_pcw = 0; e_mode = 0; e_acc = 1; e_maint = 0; e_miss = 1; cyc();
    ev_zero(); e_pcw = 1; cyc();
    ev_zero();
    wr(0, mk(0, 0, 0, 14, 11, 12));
    rd(4'd4, v); chk("R5 software PC change", v, 2);
    rd(4'd5, v); chk("R6 access without maintenance", v, 2);
    rd(4'd6, v); chk("R6 miss without maintenance", v, 1);

    // R12
    wr(0, mk(0, 1, 0, 0, 15, 8));
    wr(0, mk(1, 0, 0, 0, 15, 8));
    ev_all(); repeat (3) cyc();
    ev_zero();
    wr(0, mk(0, 0, 0, 0, 15, 8));
    rd(4'd4, v); chk("R12 code 0 silent", v, 0);
    rd(4'd5, v); chk("R12 code 15 silent", v, 0);
    rd(4'd6, v); chk("R12 retire counted", v, 3);
    rd(4'd3, v2);
    ev_all(); repeat (3) cyc(); ev_zero();
    rd(4'd3, v); chk("R12 disabled cycle counter holds", v, v2);
    rd(4'd6, v); chk("R12 disabled event counter holds", v, 3);

    // R7
    wr(5, 32'h1234_5678);
    rd(4'd5, v); chk("R7 load while disabled", v, 32'h1234_5678);
    wr(0, mk(1, 0, 0, 0, 8, 0));
    e_ret = 1;
    wr(5, 32'd100);
    ev_zero();
    wr(0, mk(0, 0, 0, 0, 8, 0));
    rd(4'd5, v); chk("R7 load beats count", v, 100);

    // R9, R10, R11
    wr(0, mk(0, 1, 0, 0, 8, 0));
    wr(5, 32'hFFFF_FFFE);
    wr(0, mk(1, 0, 4'b0100, 0, 8, 0));
    e_ret = 1; pc = 32'hA0; cyc();
    pc = 32'hB0; cyc();
    pc = 32'hC0; cyc();
    ev_zero();
    wr(0, mk(0, 0, 4'b0100, 0, 8, 0));
    rd(4'd1, v); chk("R9 flag set on wrap", v, 32'h4);
    rd(4'd2, v); chk("R11 PC captured at wrap", v, 32'hB0);
    rd(4'd5, v); chk("R9 counter after wrap", v, 1);
    chk("R10 irq with enable", {31'd0, irq}, 1);
    wr(5, 32'hFFFF_FFFF);
    wr(0, mk(1, 0, 4'b0100, 0, 8, 0));
    e_ret = 1; pc = 32'hD0; cyc();
    ev_zero();
    wr(0, mk(0, 0, 4'b0000, 0, 8, 0));
    rd(4'd2, v); chk("R11 sample held while flag set", v, 32'hB0);
    chk("R10 irq masked", {31'd0, irq}, 0);

    // R8
    wr(0, mk(0, 1, 4'b0100, 0, 8, 0));
    rd(4'd0, v); chk("R8 clear bit reads 0", v, mk(0, 0, 4'b0100, 0, 8, 0));
    rd(4'd3, v); chk("R8 cycle counter cleared", v, 0);
    rd(4'd5, v); chk("R8 event counter cleared", v, 0);
    rd(4'd1, v); chk("R8 flags kept", v, 32'h4);
    wr(1, 32'h4);
    rd(4'd1, v); chk("R9 write-one clear", v, 0);
    chk("R10 irq drops", {31'd0, irq}, 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      {e_ic, e_fs, e_dep, e_itlb, e_dtlb, e_br, e_mp, e_ret} = 8'($urandom);
      if ($urandom_range(0, 3) == 0) e_dbuf = ~e_dbuf;
      {e_acc, e_miss, e_maint, e_pcw, e_mode} = 5'($urandom);
      e_wb = 2'($urandom_range(0, 2));
      pc = $urandom;
      we = 0;
      if ($urandom_range(0, 11) == 0) begin
        we = 1;
        case ($urandom_range(0, 3))
          0: begin
            waddr = 0;
            wdata = mk($urandom_range(0, 5) != 0, $urandom_range(0, 7) == 0,
                       4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
          end
          1: begin waddr = 1; wdata = $urandom; end
          default: begin
            waddr = 4'($urandom_range(3, 3 + NC));
            wdata = 32'hFFFF_FFF0 + 32'($urandom_range(0, 15));
          end
        endcase
      end
    end
    @(negedge clk);
    we = 0;
    ev_zero();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule